// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync Field

This block serializes payload words onto a single data line, one bit per clock. A frame begins with a start event: either the framer arms itself as soon as it is enabled, or it waits for a rising edge on an external frame-sync input. After the start event it holds the line idle for a programmed number of bit slots. It can then send an optional synchronization field drawn from a pattern register. After that it streams a programmed number of payload words of programmed length, with no gap between the parts. Bit order applies to both the sync field and the payload.

Payload words arrive through a ready/valid handshake. The request comes one cycle before the word's first bit slot. A word that is not offered in time becomes an idle slot and an underrun pulse. Outside a frame the line carries a programmable default level. A one-cycle flag marks the start of every frame. Configuration inputs must stay stable while a frame is in flight.

States: `ST_OFF` (disabled), `ST_ARM` (waiting for start), `ST_DELAY`, `ST_SYNC`, `ST_DATA`. Transitions:
- OFF→ARM on enable.
- ARM→DELAY, ARM→SYNC or ARM→DATA on a start event. The target is the first non-empty phase.
- DELAY→SYNC or DELAY→DATA when the delay count expires.
- SYNC→DATA after the last sync bit.
- DATA→DATA between words.
- DATA→ARM after the last bit of the last word.
- Any state→OFF when enable is low.

Top module: `sync_tx_framer`

## Requirements
- R1: While `cfg_enable` is low, and during reset, `tx_data` equals `cfg_idle_level`, and `tx_busy`, `s_ready` and `sync_flag` are 0.
- R2: With `cfg_start_sel`=0, slot 0 of a frame is the cycle after the second rising clock edge that samples `cfg_enable` high. After each frame exactly one idle slot passes before the next frame's slot 0. With `cfg_start_sel`=1, a frame starts only on a 0→1 change of `ext_fsync` while armed. Holding `ext_fsync` high starts nothing further.
- R3: The first `cfg_delay` slots after the start event (0 to 255) carry the idle level.
- R4: When `cfg_sync_en`=1, the delay is followed by S = {`cfg_sync_len_hi`,`cfg_sync_len`}+1 bits taken from bits [S-1:0] of `cfg_sync_pattern`. The payload follows with no gap. When `cfg_sync_en`=0, no sync bits are sent.
- R5: The payload is N = `cfg_words`+1 words of L = `cfg_data_len`+1 bits, taken from bits [L-1:0] of `s_data`. Each word is requested by `s_ready` in the cycle before its first bit slot and accepted when `s_valid` is also high.
- R6: `cfg_msb_first`=1 sends bit L-1 (S-1 for sync) first. `cfg_msb_first`=0 sends bit 0 first.
- R7: If `s_valid` is low while `s_ready` is high, the whole word slot carries the idle level. `underrun` pulses in the slot's first cycle, and no word is consumed.
- R8: `sync_flag` is high for exactly one cycle, the frame's slot 0.
- R9: After the last payload bit the line returns to the idle level, and `tx_busy` falls, until the next start event.
- R10: Lowering `cfg_enable` aborts any frame. From the next cycle the line is idle and `tx_busy` is 0.
- R11: `tx_busy` is 1 in every delay, sync and payload slot of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Framer enable; low aborts and holds idle |
| cfg_start_sel | input | 1 | 0: start immediately when armed; 1: start on `ext_fsync` rising edge |
| cfg_delay | input | DELAY_W | Idle slots between start event and first framed bit |
| cfg_sync_en | input | 1 | Insert sync field |
| cfg_sync_len_hi | input | SYNC_HI_W | High part of sync length minus one |
| cfg_sync_len | input | SYNC_BASE_W | Low part of sync length minus one |
| cfg_sync_pattern | input | SYNC_W | Sync bits, used from bit 0 upward |
| cfg_data_len | input | DLEN_W | Word length minus one |
| cfg_words | input | WORDS_W | Words per frame minus one |
| cfg_msb_first | input | 1 | Bit order for sync and payload |
| cfg_idle_level | input | 1 | Level of `tx_data` outside framed bits |
| ext_fsync | input | 1 | External frame-sync request |
| s_valid | input | 1 | Payload word offered |
| s_ready | output | 1 | Payload word requested this cycle |
| s_data | input | WORD_W | Payload word |
| tx_data | output | 1 | Serial data line |
| tx_busy | output | 1 | Frame slot in progress |
| sync_flag | output | 1 | One-cycle pulse on frame start |
| underrun | output | 1 | Pulse on a word slot left empty |

## Verification
A bit counter that is off by one shifts every following bit. The bench compares whole frames bit by bit, so such an error shows within one slot of where the sync field or a word boundary begins. A wrong state after the last word shows up immediately. Either `tx_busy` stays high past the frame end, or the next `sync_flag` pulse lands in the wrong cycle. A lost underrun marker shows as payload bits where idle bits are expected, starting in the missed word's first slot. A state that ignores the enable shows as a busy line one cycle after the abort.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_DELAY,
        ST_SYNC,
        ST_DATA
    } tx_state_e;
endpackage

// File: rtl/sync_tx_rise.sv
module sync_tx_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/sync_tx_bitsel.sv
module sync_tx_bitsel #(
    parameter int IW = 5,
    localparam int W = 1 << IW
) (
    input  logic [W-1:0]  vec_i,
    input  logic [IW-1:0] last_i,
    input  logic [IW-1:0] idx_i,
    input  logic          msb_first_i,
    output logic          bit_o
);
    logic [IW-1:0] pos;

    always_comb begin
        pos   = msb_first_i ? (last_i - idx_i) : idx_i;
        bit_o = vec_i[pos];
    end
endmodule

// File: rtl/sync_tx_wordbuf.sv
module sync_tx_wordbuf #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o,
    output logic              miss_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            miss_o <= 1'b0;
        end else if (load_i) begin
            miss_o <= ~valid_i;
            if (valid_i) word_o <= data_i;
        end
    end
endmodule

// File: rtl/sync_tx_framer.sv
module sync_tx_framer
    import sync_tx_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int WORDS_W     = 4,
    parameter int SYNC_BASE_W = 4,
    parameter int SYNC_HI_W   = 1,
    parameter int DELAY_W     = 8,
    localparam int DLEN_W     = $clog2(WORD_W),
    localparam int SLEN_W     = SYNC_BASE_W + SYNC_HI_W,
    localparam int SYNC_W     = 1 << SLEN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic                   cfg_start_sel,
    input  logic [DELAY_W-1:0]     cfg_delay,
    input  logic                   cfg_sync_en,
    input  logic [SYNC_HI_W-1:0]   cfg_sync_len_hi,
    input  logic [SYNC_BASE_W-1:0] cfg_sync_len,
    input  logic [SYNC_W-1:0]      cfg_sync_pattern,
    input  logic [DLEN_W-1:0]      cfg_data_len,
    input  logic [WORDS_W-1:0]     cfg_words,
    input  logic                   cfg_msb_first,
    input  logic                   cfg_idle_level,
    input  logic                   ext_fsync,
    input  logic                   s_valid,
    output logic                   s_ready,
    input  logic [WORD_W-1:0]      s_data,
    output logic                   tx_data,
    output logic                   tx_busy,
    output logic                   sync_flag,
    output logic                   underrun
);
    localparam int CNT_A = (DELAY_W > DLEN_W) ? DELAY_W : DLEN_W;
    localparam int CNT_W = (CNT_A > SLEN_W) ? CNT_A : SLEN_W;

    tx_state_e          state, state_d;
    logic [CNT_W-1:0]   cnt, cnt_d;
    logic [WORDS_W-1:0] word_cnt, word_d;
    logic               word_start;
    logic               fs_rise;
    logic               start_evt;
    logic               sync_q;
    logic [SLEN_W-1:0]  sync_last;
    logic [WORD_W-1:0]  cur_word;
    logic               cur_miss;
    logic               sync_bit, data_bit;
    logic               last_sync_bit, last_data_bit, last_word, delay_done;

    sync_tx_rise u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ext_fsync),
        .rise_o (fs_rise)
    );

    sync_tx_wordbuf #(.WORD_W(WORD_W)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (word_start),
        .valid_i (s_valid),
        .data_i  (s_data),
        .word_o  (cur_word),
        .miss_o  (cur_miss)
    );

    sync_tx_bitsel #(.IW(SLEN_W)) u_sync_sel (
        .vec_i       (cfg_sync_pattern),
        .last_i      (sync_last),
        .idx_i       (cnt[SLEN_W-1:0]),
        .msb_first_i (cfg_msb_first),
        .bit_o       (sync_bit)
    );

    sync_tx_bitsel #(.IW(DLEN_W)) u_data_sel (
        .vec_i       (cur_word),
        .last_i      (cfg_data_len),
        .idx_i       (cnt[DLEN_W-1:0]),
        .msb_first_i (cfg_msb_first),
        .bit_o       (data_bit)
    );

    assign sync_last     = {cfg_sync_len_hi, cfg_sync_len};
    assign start_evt     = cfg_enable && (state == ST_ARM) && (cfg_start_sel ? fs_rise : 1'b1);
    assign last_sync_bit = (cnt == CNT_W'(sync_last));
    assign last_data_bit = (cnt == CNT_W'(cfg_data_len));
    assign last_word     = (word_cnt == cfg_words);
    assign delay_done    = (cnt == '0);

    // Next-state and counter logic
    always_comb begin
        state_d    = state;
        cnt_d      = cnt;
        word_d     = word_cnt;
        word_start = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (cfg_enable) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (start_evt) begin
                    cnt_d  = '0;
                    word_d = '0;
                    if (cfg_delay != '0) begin
                        state_d = ST_DELAY;
                        cnt_d   = CNT_W'(cfg_delay) - CNT_W'(1);
                    end else if (cfg_sync_en) begin
                        state_d = ST_SYNC;
                    end else begin
                        state_d    = ST_DATA;
                        word_start = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (delay_done) begin
                    if (cfg_sync_en) begin
                        state_d = ST_SYNC;
                    end else begin
                        state_d    = ST_DATA;
                        word_start = 1'b1;
                    end
                end else begin
                    cnt_d = cnt - CNT_W'(1);
                end
            end
            ST_SYNC: begin
                if (last_sync_bit) begin
                    cnt_d      = '0;
                    state_d    = ST_DATA;
                    word_start = 1'b1;
                end else begin
                    cnt_d = cnt + CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (last_data_bit) begin
                    cnt_d = '0;
                    if (last_word) begin
                        state_d = ST_ARM;
                    end else begin
                        word_d     = word_cnt + WORDS_W'(1);
                        word_start = 1'b1;
                    end
                end else begin
                    cnt_d = cnt + CNT_W'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
        if (!cfg_enable) begin
            state_d    = ST_OFF;
            word_start = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            cnt      <= '0;
            word_cnt <= '0;
            sync_q   <= 1'b0;
        end else begin
            state    <= state_d;
            cnt      <= cnt_d;
            word_cnt <= word_d;
            sync_q   <= start_evt;
        end
    end

    // Outputs
    always_comb begin
        s_ready   = word_start;
        sync_flag = sync_q;
        tx_busy   = 1'b0;
        tx_data   = cfg_idle_level;
        underrun  = 1'b0;
        unique case (state)
            ST_OFF, ST_ARM: begin
                tx_busy = 1'b0;
            end
            ST_DELAY: begin
                tx_busy = 1'b1;
            end
            ST_SYNC: begin
                tx_busy = 1'b1;
                tx_data = sync_bit;
            end
            ST_DATA: begin
                tx_busy  = 1'b1;
                tx_data  = cur_miss ? cfg_idle_level : data_bit;
                underrun = cur_miss && (cnt == '0);
            end
            default: tx_busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/sync_tx_checker.sv
module sync_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_idle_level,
    input logic tx_data,
    input logic tx_busy,
    input logic s_ready,
    input logic sync_flag,
    input logic underrun
);
    AST_ABORT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cfg_enable |=> !tx_busy); // R10
    AST_IDLE_LINE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> tx_data == cfg_idle_level); // R9
    AST_UNDERRUN_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) underrun |-> (tx_busy && tx_data == cfg_idle_level)); // R7
    AST_READY_LEADS_WORD: assert property (@(posedge clk) disable iff (!rst_n) s_ready |=> tx_busy); // R5
    AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> cfg_enable); // R1
    AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sync_flag |=> !sync_flag); // R8
    AST_FLAG_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) sync_flag |-> tx_busy); // R11
endmodule

bind sync_tx_framer sync_tx_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_idle_level (cfg_idle_level),
    .tx_data        (tx_data),
    .tx_busy        (tx_busy),
    .s_ready        (s_ready),
    .sync_flag      (sync_flag),
    .underrun       (underrun)
);

// File: tb/tb_sync_tx_framer.sv
`timescale 1ns/1ps
module tb_sync_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_start_sel = 1'b1;
    logic [7:0]  cfg_delay = '0;
    logic        cfg_sync_en = 1'b0;
    logic [0:0]  cfg_sync_len_hi = '0;
    logic [3:0]  cfg_sync_len = '0;
    logic [31:0] cfg_sync_pattern = '0;
    logic [4:0]  cfg_data_len = '0;
    logic [3:0]  cfg_words = '0;
    logic        cfg_msb_first = 1'b0, cfg_idle_level = 1'b1;
    logic        ext_fsync = 1'b0;
    logic        s_valid, s_ready;
    logic [31:0] s_data;
    logic        tx_data, tx_busy, sync_flag, underrun;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] words [0:31];
    logic        vplan [0:31];
    logic [5:0]  sc, pc;
    logic        clr = 1'b0;
    logic        exp_bits [0:1023];
    int          exp_len, exp_miss;

    always #4 clk = ~clk;

    sync_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_start_sel(cfg_start_sel),
        .cfg_delay(cfg_delay), .cfg_sync_en(cfg_sync_en), .cfg_sync_len_hi(cfg_sync_len_hi),
        .cfg_sync_len(cfg_sync_len), .cfg_sync_pattern(cfg_sync_pattern),
        .cfg_data_len(cfg_data_len), .cfg_words(cfg_words), .cfg_msb_first(cfg_msb_first),
        .cfg_idle_level(cfg_idle_level), .ext_fsync(ext_fsync), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .tx_data(tx_data), .tx_busy(tx_busy),
        .sync_flag(sync_flag), .underrun(underrun)
    );

    assign s_valid = vplan[sc[4:0]];
    assign s_data  = words[pc[4:0]];

    always @(posedge clk) begin
        if (clr) begin
            sc <= '0;
            pc <= '0;
        end else if (s_ready) begin
            sc <= sc + 6'd1;
            if (s_valid) pc <= pc + 6'd1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected line contents for one frame, from R3..R7
    task automatic build_expected();
        int p = 0;
        int slen = {cfg_sync_len_hi, cfg_sync_len} + 1;
        int dlen = cfg_data_len + 1;
        exp_len = 0;
        exp_miss = 0;
        for (int i = 0; i < cfg_delay; i++) exp_bits[exp_len++] = cfg_idle_level;
        if (cfg_sync_en)
            for (int i = 0; i < slen; i++)
                exp_bits[exp_len++] = cfg_sync_pattern[cfg_msb_first ? slen - 1 - i : i];
        for (int w = 0; w <= cfg_words; w++) begin
            if (vplan[w]) begin
                for (int i = 0; i < dlen; i++)
                    exp_bits[exp_len++] = words[p][cfg_msb_first ? dlen - 1 - i : i];
                p++;
            end else begin
                exp_miss++;
                for (int i = 0; i < dlen; i++) exp_bits[exp_len++] = cfg_idle_level;
            end
        end
    endtask

    // imm=0: framer already armed, started by ext_fsync edge
    // imm=1: enable raised here with start_sel=0
    task automatic run_frame(input bit imm, input string name);
        int errs = 0, first_bad = -1, flag_bad = 0, busy_bad = 0, ur = 0;
        build_expected();
        @(negedge clk) clr = 1'b1;
        @(posedge clk);
        @(negedge clk) clr = 1'b0;
        if (imm) begin
            cfg_enable = 1'b1;
            @(posedge clk);
            @(posedge clk);
        end else begin
            ext_fsync = 1'b1;
            @(posedge clk);
        end
        for (int s = 0; s < exp_len; s++) begin
            @(negedge clk);
            if (tx_data !== exp_bits[s]) begin
                errs++;
                if (first_bad < 0) first_bad = s;
            end
            if (sync_flag !== (s == 0)) flag_bad++;
            if (tx_busy !== 1'b1) busy_bad++;
            if (underrun) ur++;
        end
        check(errs == 0, $sformatf("R3/R4/R5/R6 %s bit errors (first slot %0d)", name, first_bad), errs, 0);
        check(flag_bad == 0, $sformatf("R8 %s sync_flag slots wrong", name), flag_bad, 0);
        check(busy_bad == 0, $sformatf("R11 %s busy gaps", name), busy_bad, 0);
        check(ur == exp_miss, $sformatf("R7 %s underrun pulses", name), ur, exp_miss);
        @(negedge clk);
        check(tx_busy === 1'b0 && tx_data === cfg_idle_level,
              $sformatf("R9 %s line after frame busy/data", name), {tx_busy, tx_data}, {1'b0, cfg_idle_level});
        if (imm) begin
            @(negedge clk);
            check(sync_flag === 1'b1, $sformatf("R2 %s restart after one idle slot", name), sync_flag, 1);
            cfg_enable = 1'b0;
            @(negedge clk);
            check(tx_busy === 1'b0 && tx_data === cfg_idle_level, $sformatf("R10 %s disable", name),
                  {tx_busy, tx_data}, {1'b0, cfg_idle_level});
        end
        ext_fsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill_payload(input int miss_every);
        for (int i = 0; i < 32; i++) begin
            words[i] = $urandom;
            vplan[i] = (miss_every == 0) ? 1'b1 : (($urandom % miss_every) != 0);
        end
    endtask

    task automatic arm_ext();
        cfg_start_sel = 1'b1;
        cfg_enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int busy_seen, rdy_seen;
        void'($urandom(32'd7741));
        fill_payload(0);
        cfg_idle_level = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_data === 1'b1 && tx_busy === 1'b0 && s_ready === 1'b0 && sync_flag === 1'b0,
              "R1 reset state", {tx_data, tx_busy, s_ready, sync_flag}, 4'b1000);
        rst_n = 1'b1;
        cfg_idle_level = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_data === 1'b0 && tx_busy === 1'b0 && s_ready === 1'b0,
              "R1 disabled idle level 0", {tx_data, tx_busy, s_ready}, 3'b000);

        // Directed: minimal frame, MSB first
        cfg_data_len = 5'd7; cfg_words = 0; cfg_msb_first = 1; cfg_delay = 0; cfg_sync_en = 0;
        words[0] = 32'h0000_00A6;
        arm_ext();
        run_frame(0, "min_msb");

        // Directed: delay + short sync, LSB first, two 12-bit words
        cfg_delay = 3; cfg_sync_en = 1; cfg_sync_len_hi = 0; cfg_sync_len = 4;
        cfg_sync_pattern = 32'h0000_0013; cfg_data_len = 11; cfg_words = 1; cfg_msb_first = 0;
        cfg_idle_level = 1;
        run_frame(0, "sync_lsb");

        // Directed: longest everything
        cfg_delay = 8'd255; cfg_sync_len_hi = 1; cfg_sync_len = 4'hF; cfg_sync_pattern = 32'hC35A_0F81;
        cfg_data_len = 5'd31; cfg_words = 4'hF; cfg_msb_first = 1; cfg_idle_level = 0;
        fill_payload(0);
        run_frame(0, "max_sizes");

        // Directed: underrun in the middle word
        cfg_delay = 1; cfg_sync_en = 0; cfg_data_len = 5; cfg_words = 2; cfg_idle_level = 1;
        vplan[1] = 1'b0;
        run_frame(0, "underrun_mid");

        // Directed: ext_fsync held high starts no further frame
        fill_payload(0);
        cfg_delay = 0; cfg_words = 0;
        ext_fsync = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ext_fsync = 1'b1;
        busy_seen = 0; rdy_seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i > 10) begin
                busy_seen += tx_busy;
                rdy_seen += s_ready;
            end
        end
        check(busy_seen == 0 && rdy_seen == 0, "R2 level-held sync starts nothing after first frame",
              busy_seen + rdy_seen, 0);
        ext_fsync = 1'b0;
        @(negedge clk);

        // Directed: abort mid delay
        cfg_delay = 10;
        ext_fsync = 1'b1;
        repeat (5) @(negedge clk);
        check(tx_busy === 1'b1, "R11 busy during delay", tx_busy, 1);
        cfg_enable = 1'b0;
        @(negedge clk);
        check(tx_busy === 1'b0 && tx_data === cfg_idle_level, "R10 abort mid delay",
              {tx_busy, tx_data}, {1'b0, cfg_idle_level});
        ext_fsync = 1'b0;
        @(negedge clk);

        // Directed: immediate start mode with restart
        cfg_start_sel = 1'b0; cfg_delay = 2; cfg_sync_en = 1; cfg_sync_len = 2;
        cfg_sync_len_hi = 0; cfg_sync_pattern = 32'h5; cfg_data_len = 3; cfg_words = 1;
        fill_payload(0);
        run_frame(1, "immediate");

        // Random frames
        arm_ext();
        for (int n = 0; n < 30; n++) begin
            cfg_delay        = (($urandom % 4) == 0) ? 8'($urandom % 256) : 8'($urandom % 5);
            cfg_sync_en      = 1'($urandom);
            cfg_sync_len_hi  = 1'($urandom);
            cfg_sync_len     = 4'($urandom);
            cfg_sync_pattern = $urandom;
            cfg_data_len     = 5'($urandom);
            cfg_words        = 4'($urandom % 8);
            cfg_msb_first    = 1'($urandom);
            cfg_idle_level   = 1'($urandom);
            fill_payload(6);
            run_frame(0, $sformatf("rand%0d", n));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule